// File: doc/BRIEF.md
# Predictive Dead-Time PWM Controller

This block drives the two switches of a synchronous buck stage. A free-running tick counter sets the switching period. The high-side gate is on for a fixed number of ticks at the start of every period. The low-side gate fills the rest of the period, except for a guard interval of `dt_now` ticks on each side: one after the high-side turn-off and one before the next high-side turn-on.

The guard interval is trimmed once per switching period. An external comparator watches the low-side switch for body-diode conduction and presents a one-bit flag. The block samples that flag on the first tick after the high-side gate turns off.

- A set flag means the guard was longer than needed, so the next period uses one tick less.
- A clear flag means the guard may be too short, so the next period uses one tick more.

The value saturates at `DT_MIN` and `DT_MAX`, so it never reaches zero. A new value always takes effect at a period boundary. In steady operation the guard interval settles and then alternates by one tick around the point where conduction stops being seen.

Top module: `dtpred_pwm`

## Requirements
- R1: While `rst_n` is low, both gates are low and `dt_now` equals `cfg_dt_init` clamped into [`DT_MIN`, `DT_MAX`] (defaults 2 and 40).
- R2: After reset, a period lasts `cfg_period` ticks. The high-side gate is high for exactly the first `cfg_hs_on` ticks of each period, counting from tick 0.
- R3: Within a period, the low-side gate is high on ticks t with `cfg_hs_on + dt_now` <= t < `cfg_period - dt_now`, and low on all other ticks.
- R4: The two gates are never high together. The low-side gate is always low on the tick before a high-side rising edge.
- R5: The flag is sampled on tick `cfg_hs_on`, the first tick with the high side off. If it is 1, the next period uses `dt_now - 1`.
- R6: If the sampled flag is 0, the next period uses `dt_now + 1`.
- R7: `dt_now` saturates: it never goes below `DT_MIN` or above `DT_MAX`.
- R8: `dt_now` changes only on the tick where a new period starts (high-side rising edge), and then by exactly one.
- R9: With a conduction flag that is 1 whenever the guard exceeds a threshold T, the guard interval converges and then alternates between T and T+1.
- R10: The first period after reset uses the clamped starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| diode_flag | input | 1 | Body-diode conduction seen on the low-side switch |
| cfg_period | input | CNT_W | Period length in ticks |
| cfg_hs_on | input | CNT_W | High-side on-time in ticks |
| cfg_dt_init | input | DT_W | Starting guard interval in ticks |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| dt_now | output | DT_W | Guard interval used in the current period |

## Verification
The assertions assume the configuration inputs hold still while reset is released, and that `cfg_hs_on` >= 1. They also assume `cfg_hs_on` plus twice the largest guard value reached fits inside `cfg_period`. Under those conditions the low-side window cannot wrap or underflow. The flag input is taken as arbitrary, since the trim logic must stay in bounds whatever it sees.

The stimulus changes configuration only while reset is held. It picks period, on-time and threshold pairs whose reachable guard values satisfy the fit condition. The flag comes from a threshold model of the power stage evaluated on the falling clock edge.

// File: rtl/dtpred_pkg.sv
// Shared types for the predictive dead-time PWM controller.
// Assumes nothing beyond being compiled before the modules that import it.
package dtpred_pkg;

    // Direction of the per-period guard-interval adjustment.
    typedef enum logic [0:0] {
        TRIM_UP   = 1'b0,
        TRIM_DOWN = 1'b1
    } trim_dir_e;

endpackage

// File: rtl/dtpred_timebase.sv
// Period timebase: counts ticks 0 .. cfg_period-1 and marks the period end
// and the high-side turn-off tick.
// Assumes cfg_period >= 2 and cfg_hs_on < cfg_period, stable outside reset.
module dtpred_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_hs_on,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             hs_off_tick
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic last;

    // Purpose: detect the final tick of the period.
    always_comb begin
        last = (cnt == (cfg_period - ONE));
    end

    // Purpose: advance the tick counter once running; hold tick 0 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            run <= 1'b1;
            if (run) begin
                cnt <= last ? '0 : cnt + ONE;
            end
        end
    end

    // Purpose: period-end strobe and flag-sampling strobe.
    always_comb begin
        wrap        = run && last;
        hs_off_tick = run && (cnt == cfg_hs_on);
    end

endmodule

// File: rtl/dtpred_trim.sv
// Guard-interval tracker: predicts the next period's dead time from the
// conduction flag sampled in this period and applies it at the period end.
// Assumes sample_en and period_end are single-tick strobes.
module dtpred_trim
    import dtpred_pkg::*;
#(
    parameter int DT_W   = 8,
    parameter int DT_MIN = 2,
    parameter int DT_MAX = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] cfg_dt_init,
    input  logic            sample_en,
    input  logic            diode_flag,
    input  logic            period_end,
    output logic [DT_W-1:0] dt_act
);
    localparam logic [DT_W-1:0] MIN_V = DT_W'(DT_MIN);
    localparam logic [DT_W-1:0] MAX_V = DT_W'(DT_MAX);
    localparam logic [DT_W-1:0] ONE   = DT_W'(1);

    logic [DT_W-1:0] dt_pend;
    logic [DT_W-1:0] init_sat;
    logic [DT_W-1:0] dt_trial;
    trim_dir_e       dir;

    // Purpose: clamp the configured start value into the legal range.
    always_comb begin
        if (cfg_dt_init < MIN_V)      init_sat = MIN_V;
        else if (cfg_dt_init > MAX_V) init_sat = MAX_V;
        else                          init_sat = cfg_dt_init;
    end

    // Purpose: form the one-step saturating prediction for the next period.
    always_comb begin
        dir = diode_flag ? TRIM_DOWN : TRIM_UP;
        if (dir == TRIM_DOWN) begin
            dt_trial = (dt_act > MIN_V) ? dt_act - ONE : MIN_V;
        end else begin
            dt_trial = (dt_act < MAX_V) ? dt_act + ONE : MAX_V;
        end
    end

    // Purpose: hold the pending prediction and apply it only at a period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_pend <= init_sat;
            dt_act  <= init_sat;
        end else begin
            if (sample_en) begin
                dt_pend <= dt_trial;
            end
            if (period_end) begin
                dt_act <= dt_pend;
            end
        end
    end

endmodule

// File: rtl/dtpred_gates.sv
// Gate shaper: decodes the tick count into the high-side pulse and the
// guarded low-side pulse.
// Assumes cfg_hs_on + 2*dt_act <= cfg_period so the low window cannot wrap.
module dtpred_gates #(
    parameter int CNT_W = 8,
    parameter int DT_W  = 8
) (
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_hs_on,
    input  logic [DT_W-1:0]  dt_act,
    output logic             hs_gate,
    output logic             ls_gate
);
    localparam int SUM_W = ((CNT_W > DT_W) ? CNT_W : DT_W) + 1;

    logic [SUM_W-1:0] cnt_x;
    logic [SUM_W-1:0] lo_start;
    logic [SUM_W-1:0] lo_end;
    logic             live;

    // Purpose: widen operands and locate the low-side window edges.
    always_comb begin
        cnt_x    = SUM_W'(cnt);
        lo_start = SUM_W'(cfg_hs_on) + SUM_W'(dt_act);
        lo_end   = SUM_W'(cfg_period) - SUM_W'(dt_act);
        live     = rst_n && run;
    end

    // Purpose: drive both gates, forced low until the counter runs.
    always_comb begin
        hs_gate = live && (cnt < cfg_hs_on);
        ls_gate = live && (cnt_x >= lo_start) && (cnt_x < lo_end);
    end

endmodule

// File: rtl/dtpred_pwm.sv
// Top level of the predictive dead-time PWM controller: a tick timebase,
// a per-period guard-interval tracker and a gate shaper.
// Assumes configuration is changed only while rst_n is low.
module dtpred_pwm #(
    parameter int CNT_W  = 8,
    parameter int DT_W   = 8,
    parameter int DT_MIN = 2,
    parameter int DT_MAX = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             diode_flag,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_hs_on,
    input  logic [DT_W-1:0]  cfg_dt_init,
    output logic             hs_gate,
    output logic             ls_gate,
    output logic [DT_W-1:0]  dt_now
);
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             hs_off_tick;
    logic [DT_W-1:0]  dt_act;

    dtpred_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_period  (cfg_period),
        .cfg_hs_on   (cfg_hs_on),
        .run         (run),
        .cnt         (cnt),
        .wrap        (wrap),
        .hs_off_tick (hs_off_tick)
    );

    dtpred_trim #(.DT_W(DT_W), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u_trim (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_dt_init (cfg_dt_init),
        .sample_en   (hs_off_tick),
        .diode_flag  (diode_flag),
        .period_end  (wrap),
        .dt_act      (dt_act)
    );

    dtpred_gates #(.CNT_W(CNT_W), .DT_W(DT_W)) u_gates (
        .rst_n      (rst_n),
        .run        (run),
        .cnt        (cnt),
        .cfg_period (cfg_period),
        .cfg_hs_on  (cfg_hs_on),
        .dt_act     (dt_act),
        .hs_gate    (hs_gate),
        .ls_gate    (ls_gate)
    );

    // Purpose: expose the guard interval in use.
    always_comb begin
        dt_now = dt_act;
    end

endmodule

// File: rtl/dtpred_pwm_chk.sv
// Property checker for dtpred_pwm, bound to every instance of the top.
// Assumes the configuration constraints listed in the brief.
module dtpred_pwm_chk #(
    parameter int DT_W   = 8,
    parameter int DT_MIN = 2,
    parameter int DT_MAX = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hs_gate,
    input logic            ls_gate,
    input logic [DT_W-1:0] dt_now
);
    // R1: gates low throughout reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!hs_gate && !ls_gate));

    // R4: no overlap
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R4: low side already off before a high-side rising edge
    a_r4_guard_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> !$past(ls_gate));

    // R7: saturation bounds
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_now >= DT_W'(DT_MIN)) && (dt_now <= DT_W'(DT_MAX)));

    // R8: changes only at the period start
    a_r8_change_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_now != $past(dt_now)) |-> (hs_gate && !$past(hs_gate)));

    // R8: one step at a time
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_now == $past(dt_now)) || (dt_now == $past(dt_now) + DT_W'(1))
        || (dt_now + DT_W'(1) == $past(dt_now)));

endmodule

bind dtpred_pwm dtpred_pwm_chk #(.DT_W(DT_W), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_gate (hs_gate),
    .ls_gate (ls_gate),
    .dt_now  (dt_now)
);

// File: tb/dtpred_pwm_bench.sv
// Scoreboard bench: the driver pushes the expected guard value of every
// period; the monitor pops one at each period start and checks gate timing.
module dtpred_pwm_bench;
    localparam int CNT_W = 8;
    localparam int DT_W  = 8;
    localparam int DMIN  = 2;
    localparam int DMAX  = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             diode_flag = 1'b0;
    logic [CNT_W-1:0] cfg_period = 8'd100;
    logic [CNT_W-1:0] cfg_hs_on = 8'd20;
    logic [DT_W-1:0]  cfg_dt_init = 8'd26;
    logic             hs_gate;
    logic             ls_gate;
    logic [DT_W-1:0]  dt_now;

    int n_cmp = 0;
    int n_bad = 0;
    int thr = 10;
    int exp_q[$];
    int cur_dt = -1;
    int pos = 0;
    int last_dt = -1;
    int prev_dt = -1;
    int cycles = 0;
    bit prev_hs = 1'b0;
    bit done = 1'b0;

    dtpred_pwm #(.CNT_W(CNT_W), .DT_W(DT_W), .DT_MIN(DMIN), .DT_MAX(DMAX)) u_dtpred_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .diode_flag  (diode_flag),
        .cfg_period  (cfg_period),
        .cfg_hs_on   (cfg_hs_on),
        .cfg_dt_init (cfg_dt_init),
        .hs_gate     (hs_gate),
        .ls_gate     (ls_gate),
        .dt_now      (dt_now)
    );

    always #4 clk = ~clk;

    function automatic int clampv(int v);
        return (v < DMIN) ? DMIN : ((v > DMAX) ? DMAX : v);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Power-stage model: conduction seen whenever the guard exceeds thr.
    always @(negedge clk) diode_flag <= (int'(dt_now) > thr);

    // Monitor: pop the expected guard at each period start, check each tick.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hs_gate && !prev_hs) begin
                pos = 0;
                if (exp_q.size() > 0) begin
                    cur_dt = exp_q.pop_front();
                    check(int'(dt_now) == cur_dt, "R5 R6 R8 R10 period guard", int'(dt_now), cur_dt);
                    prev_dt = last_dt;
                    last_dt = int'(dt_now);
                end else begin
                    cur_dt = -1;
                end
            end else begin
                pos++;
            end
            if (cur_dt >= 0) begin
                check(hs_gate == (pos < int'(cfg_hs_on)), "R2 high-side pulse", int'(hs_gate),
                      int'(pos < int'(cfg_hs_on)));
                check(ls_gate == ((pos >= int'(cfg_hs_on) + cur_dt) && (pos < int'(cfg_period) - cur_dt)),
                      "R3 low-side window", int'(ls_gate),
                      int'((pos >= int'(cfg_hs_on) + cur_dt) && (pos < int'(cfg_period) - cur_dt)));
                check(!(hs_gate && ls_gate), "R4 overlap", int'(hs_gate && ls_gate), 0);
            end
        end else begin
            cur_dt = -1;
        end
        prev_hs = hs_gate;
    end

    // Driver: one configuration, expected guard per period pushed up front.
    task automatic run_case(int p, int h, int init, int t, int n);
        int d;
        rst_n = 1'b0;
        cfg_period = CNT_W'(p);
        cfg_hs_on = CNT_W'(h);
        cfg_dt_init = DT_W'(init);
        thr = t;
        last_dt = -1;
        prev_dt = -1;
        repeat (3) @(negedge clk);
        check(!hs_gate && !ls_gate, "R1 gates low in reset", int'(hs_gate | ls_gate), 0);
        check(int'(dt_now) == clampv(init), "R1 start value clamp", int'(dt_now), clampv(init));
        d = clampv(init);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(d);
            d = (d > t) ? clampv(d - 1) : clampv(d + 1);
        end
        @(negedge clk) rst_n = 1'b1;
        wait (exp_q.size() == 0);
        repeat (p + 2) @(negedge clk);
    endtask

    initial begin
        // R9: converge from above to dither at thr, thr+1
        run_case(100, 20, 26, 10, 30);
        check(((last_dt == 10) || (last_dt == 11)) && ((last_dt - prev_dt == 1) || (prev_dt - last_dt == 1)),
              "R9 dither around threshold", last_dt, 10);
        // R5 R7: conduction always seen, floor at minimum
        run_case(100, 20, 26, 0, 30);
        check(last_dt == DMIN, "R7 floor", last_dt, DMIN);
        // R6 R7: conduction never seen, ceiling at maximum
        run_case(100, 20, 30, 255, 16);
        check(last_dt == DMAX, "R7 ceiling", last_dt, DMAX);
        // R1 R10: out-of-range start values
        run_case(100, 20, 1, 255, 4);
        run_case(100, 20, 200, 0, 4);
        // R9: converge from below with another period
        run_case(120, 30, 5, 8, 12);
        check((last_dt == 8) || (last_dt == 9), "R9 dither from below", last_dt, 8);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule